// File: doc/BRIEF.md
# Half-Integer Clock Divider

This block divides a clock by a ratio taken from a fixed set of integer and half-integer values. It is modelled on a fast timebase whose tick is one quarter of the nominal input-clock period, so one input half-period is two ticks and one output period at ratio R lasts 4R ticks. The divided waveform and a one-tick strobe at the start of each output period leave the block as registered outputs.

A 5-bit code picks the ratio. A mode input selects how half-integer ratios are shaped. In one mode every ratio gives an even duty cycle. In the other, a ratio of k+0.5 gives k input half-periods high and k+1 low. An optional divide-by-two prescaler doubles every count. Codes outside the table are ignored. Every setting is sampled only when an output period begins, so a change never leaves a runt pulse.

Top module: `halfint_clk_div`

## Requirements
- R1: While rst_ni is low, clk_o and period_start_o are both low.
- R2: On the first tick after reset is released, clk_o goes high and period_start_o pulses.
- R3: Codes 0 to 12 select ratio 1.5 + 0.5*code, and codes 13 to 21 select ratio code - 5. The distance between two period_start_o pulses is 4R ticks.
- R4: With hi_freq_i low, clk_o is high for exactly 2R ticks of each 4R-tick period, for every legal ratio.
- R5: With hi_freq_i high and an integer ratio R, clk_o is high for 2R ticks and low for 2R ticks.
- R6: With hi_freq_i high and a ratio of k+0.5, clk_o is high for 2k ticks and low for 2k+2 ticks (ratio 1.5 gives 2 ticks high and 4 low).
- R7: With prediv_en_i high, both the period and the high time are twice the counts given by R3 to R6.
- R8: After reset, if no legal code has been applied, the ratio is 2 (8-tick period, 4 ticks high).
- R9: A code of 22 or more is ignored, and the last legal ratio stays in use.
- R10: Ratio, mode and prescale changes made during a period take effect only at the next period boundary. The current period completes with its old length, and clk_o rises only together with period_start_o.
- R11: period_start_o is one tick wide, and clk_o is high on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast timebase clock, four ticks per nominal input period |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ratio_sel_i | input | 5 | Ratio code, legal values 0 to 21 in ascending ratio order |
| hi_freq_i | input | 1 | 1: half-integer ratios use a k/(k+1) split; 0: even duty |
| prediv_en_i | input | 1 | Enables the divide-by-two prescaler |
| clk_o | output | 1 | Divided waveform |
| period_start_o | output | 1 | One-tick strobe on the first tick of each output period |

## Verification
The hardest case to reach is a settings change that lands in the middle of a long period. The old length must be kept to the end of that period, and the new length must follow at once. The stimulus waits for a strobe at ratio 16, switches to ratio 1.5 a few ticks later, and then times both that period and the one after it. A second hard case is an illegal code following a legal one, which would otherwise look the same as a correct hold. The bench uses a ratio whose timing differs from the reset default, so a divider that falls back to the default gets caught.

// File: rtl/halfint_div_pkg.sv
package halfint_div_pkg;
  localparam int SEL_W        = 5;
  localparam int NUM_RATIOS   = 22;
  localparam int HALF_STEPS   = 13;  // codes below this are the 1.5..7.5 group
  localparam int DEFAULT_CODE = 1;   // ratio 2
  localparam int HALF_W       = 6;   // 2*R, max 32
  localparam int CNT_W        = HALF_W + 2;  // 4R with prescale, max 128

  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [HALF_W-1:0] half_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // ratio expressed in half units (2*R)
  function automatic half_t half_units(sel_t code);
    if (code < SEL_W'(HALF_STEPS)) return HALF_W'(code) + HALF_W'(3);
    else                           return HALF_W'({code - SEL_W'(5), 1'b0});
  endfunction
endpackage

// File: rtl/halfint_ratio_hold.sv
module halfint_ratio_hold
  import halfint_div_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  sel_t sel_i,
  output sel_t code_o
);
  sel_t code_q;
  logic legal;

  assign legal  = sel_i < SEL_W'(NUM_RATIOS);
  assign code_o = legal ? sel_i : code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= SEL_W'(DEFAULT_CODE);
    else         code_q <= code_o;
  end
endmodule

// File: rtl/halfint_timing.sv
module halfint_timing
  import halfint_div_pkg::*;
(
  input  sel_t code_i,
  input  logic hi_freq_i,
  input  logic prediv_en_i,
  output cnt_t period_o,
  output cnt_t high_o
);
  half_t h;
  half_t h_high;
  cnt_t  per_base;
  cnt_t  high_base;

  assign h         = half_units(code_i);
  // uneven split only for odd half units in high-frequency mode
  assign h_high    = (hi_freq_i && h[0]) ? h - HALF_W'(1) : h;
  assign per_base  = {1'b0, h, 1'b0};
  assign high_base = CNT_W'(h_high);

  assign period_o  = prediv_en_i ? {per_base[CNT_W-2:0], 1'b0}  : per_base;
  assign high_o    = prediv_en_i ? {high_base[CNT_W-2:0], 1'b0} : high_base;
endmodule

// File: rtl/halfint_wave.sv
module halfint_wave
  import halfint_div_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cnt_t period_i,
  input  cnt_t high_i,
  output logic wrap_o,
  output logic wave_o,
  output logic start_o
);
  logic run_q;
  cnt_t cnt_q, cnt_nxt, per_q, high_q;
  logic wave_q, start_q;

  assign cnt_nxt = cnt_q + CNT_W'(1);
  assign wrap_o  = !run_q || (cnt_nxt == per_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      per_q   <= '0;
      high_q  <= '0;
      wave_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      run_q   <= 1'b1;
      start_q <= wrap_o;
      if (wrap_o) begin
        cnt_q  <= '0;
        per_q  <= period_i;
        high_q <= high_i;
        wave_q <= 1'b1;  // high time is never zero
      end else begin
        cnt_q  <= cnt_nxt;
        wave_q <= cnt_nxt < high_q;
      end
    end
  end

  assign wave_o  = wave_q;
  assign start_o = start_q;
endmodule

// File: rtl/halfint_clk_div.sv
module halfint_clk_div
  import halfint_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] ratio_sel_i,
  input  logic             hi_freq_i,
  input  logic             prediv_en_i,
  output logic             clk_o,
  output logic             period_start_o
);
  sel_t code;
  cnt_t period, high;
  logic wrap;

  halfint_ratio_hold u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (ratio_sel_i),
    .code_o (code)
  );

  halfint_timing u_timing (
    .code_i      (code),
    .hi_freq_i   (hi_freq_i),
    .prediv_en_i (prediv_en_i),
    .period_o    (period),
    .high_o      (high)
  );

  halfint_wave u_wave (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .period_i (period),
    .high_i   (high),
    .wrap_o   (wrap),
    .wave_o   (clk_o),
    .start_o  (period_start_o)
  );

  logic unused_wrap;
  assign unused_wrap = wrap;
endmodule

// File: rtl/halfint_clk_div_chk.sv
module halfint_clk_div_chk
  import halfint_div_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic clk_o,
  input logic period_start_o
);
  logic seen1_q, seen2_q;
  cnt_t gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen1_q <= 1'b0;
      seen2_q <= 1'b0;
      gap_q   <= '0;
    end else begin
      seen1_q <= 1'b1;
      seen2_q <= seen1_q;
      if (period_start_o)     gap_q <= '0;
      else if (&gap_q == 1'b0) gap_q <= gap_q + CNT_W'(1);
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!clk_o && !period_start_o));

  p_first_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen1_q && !seen2_q) |-> (clk_o && period_start_o));

  p_period_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen2_q |-> (gap_q < CNT_W'(128)));

  p_rise_on_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_o) |-> period_start_o);

  p_min_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_o) |=> clk_o);

  p_start_high_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_o |-> clk_o);

  p_start_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_o |=> !period_start_o);
endmodule

bind halfint_clk_div halfint_clk_div_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .clk_o          (clk_o),
  .period_start_o (period_start_o)
);

// File: tb/halfint_clk_div_tb.sv
module halfint_clk_div_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] sel = 5'd31;
  logic       hf = 1'b0;
  logic       pre = 1'b0;
  logic       clk_o, stb_o;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  halfint_clk_div u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .ratio_sel_i    (sel),
    .hi_freq_i      (hf),
    .prediv_en_i    (pre),
    .clk_o          (clk_o),
    .period_start_o (stb_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int hu(input int code);
    return (code < 13) ? code + 3 : 2 * (code - 5);
  endfunction

  function automatic int exp_per(input int eff, input int p);
    return 2 * hu(eff) * (p ? 2 : 1);
  endfunction

  function automatic int exp_high(input int eff, input int m, input int p);
    int h = hu(eff);
    return ((m != 0 && (h % 2) == 1) ? h - 1 : h) * (p ? 2 : 1);
  endfunction

  // count one period starting at a strobe tick
  task automatic time_period(output int tot, output int hi);
    tot = 0; hi = 0;
    do begin
      tot++;
      if (clk_o) hi++;
      @(negedge clk);
    end while (!stb_o && tot < 400);
  endtask

  task automatic measure(input int code, input int m, input int p, input int eff,
                         input string req);
    int tot, hi, guard;
    sel = 5'(code); hf = m[0]; pre = p[0];
    guard = 0;
    do begin @(negedge clk); guard++; end while (!stb_o && guard < 400);
    check(clk_o == 1'b1, "R11", int'(clk_o), 1);
    time_period(tot, hi);
    check(tot == exp_per(eff, p), {req, " period"}, tot, exp_per(eff, p));
    check(hi == exp_high(eff, m, p), {req, " high"}, hi, exp_high(eff, m, p));
  endtask

  task automatic t_reset_default;
    int tot, hi;
    repeat (3) @(negedge clk);
    check(clk_o == 1'b0, "R1 clk_o", int'(clk_o), 0);
    check(stb_o == 1'b0, "R1 strobe", int'(stb_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(clk_o == 1'b1, "R2 clk_o", int'(clk_o), 1);
    check(stb_o == 1'b1, "R2 strobe", int'(stb_o), 1);
    time_period(tot, hi);  // code 31 held since reset
    check(tot == 8, "R8 period", tot, 8);
    check(hi == 4, "R8 high", hi, 4);
  endtask

  task automatic t_low_freq;
    foreach (lst[i]) measure(lst[i], 0, 0, lst[i], "R3 R4");
  endtask
  int lst[7] = '{0, 1, 2, 7, 12, 13, 21};

  task automatic t_high_freq;
    measure(0, 1, 0, 0, "R6 1.5");
    measure(4, 1, 0, 4, "R6 3.5");
    measure(12, 1, 0, 12, "R6 7.5");
    measure(1, 1, 0, 1, "R5 2");
    measure(15, 1, 0, 15, "R5 10");
  endtask

  task automatic t_prescale;
    measure(0, 1, 1, 0, "R7 1.5 hf");
    measure(13, 0, 1, 13, "R7 8");
    measure(3, 0, 1, 3, "R7 3");
  endtask

  task automatic t_illegal;
    measure(5, 0, 0, 5, "R9 legal");
    measure(25, 0, 0, 5, "R9 code 25");
    measure(31, 1, 0, 5, "R9 code 31");
  endtask

  task automatic t_boundary;
    int tot, hi;
    measure(21, 0, 0, 21, "R10 setup");
    tot = 0; hi = 0;
    do begin
      tot++;
      if (tot == 4) begin sel = 5'd0; hf = 1'b1; end
      @(negedge clk);
    end while (!stb_o && tot < 400);
    check(tot == 64, "R10 old period kept", tot, 64);
    time_period(tot, hi);
    check(tot == 6, "R10 new period", tot, 6);
    check(hi == 2, "R10 new high", hi, 2);
  endtask

  initial begin
    t_reset_default();
    t_low_freq();
    t_high_freq();
    t_prescale();
    t_illegal();
    t_boundary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule